// File: doc/BRIEF.md
# Subtractive GCD Unit

This block computes the greatest common divisor of two nonzero unsigned operands by repeated subtraction. It is built as an explicit controller and datapath pair. A thirteen-state controller drives named select and load lines. The datapath holds two working registers, two subtractors, an inequality flag, a less-than flag and a result register.

A caller places two operands on the operand inputs and raises the start input. The operands must stay stable until the unit has captured both of them. The unit captures the first operand and then the second, each in its own state. It then subtracts the smaller working value from the larger until the two are equal. At that point it copies the common value into the result register and returns to wait for the next start. The result register keeps its value between computations.

Top module: `gcd_sub_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the controller goes to its idle state (code 0) and `gcd_out` becomes 0. After a reset, `gcd_out` reads 0 until the first computation finishes.
- R2: The controller tests `start` only in its wait state (code 1). When `start` is low there, it moves to the join state (code 2), and the join state always returns to the wait state. Holding `start` high for two consecutive rising edges therefore always starts a computation. With `start` low, changes on the operand inputs have no effect on `gcd_out`.
- R3: After `start` is accepted, the first working register loads `opnd_a` in the load-A state (code 3). In the next state (code 4), the second working register loads `opnd_b`. Select value 0 picks the external operand.
- R4: In each iteration, the controller moves from the inequality test (code 5) to the ordering test (code 6). If A < B, the state B-update (code 7) replaces B with B−A. Otherwise, the state A-update (code 8) replaces A with A−B. Select value 1 picks the subtractor output. A subtraction never runs on a pair where it would wrap below zero.
- R5: Each update passes through the inner join (code 9) and the outer join (code 10), then returns to the inequality test.
- R6: When A equals B at the inequality test, the controller moves to the output state (code 11). That state loads A into the result register, and the new value is visible on `gcd_out` after that edge.
- R7: The result register changes only in the output state. While a computation is running, `gcd_out` keeps the previous result.
- R8: After the output state, the controller passes through loop-back (code 12) and idle (code 0) to the wait state. The state register never holds a code above 12.
- R9: For any nonzero operands, including equal operands and operands of 1, `gcd_out` ends up equal to their greatest common divisor.
- R10: A reset during a computation abandons it. A later start then computes a correct new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a computation, sampled in the wait state |
| opnd_a | input | WIDTH | First operand, nonzero |
| opnd_b | input | WIDTH | Second operand, nonzero |
| gcd_out | output | WIDTH | Result register |

## Verification
Checks that run on every cycle inside the RTL cover several properties:
- the legal state range and the fixed walk from one state to the next;
- the capture of each operand in its own load state;
- the absence of wrapping subtractions;
- that the result is loaded only when the working values are equal;
- that the result holds at all other times.

Only the bench scenarios can show the rest:
- that the final value is the true greatest common divisor across many operand pairs, including equal pairs and pairs containing 1;
- that a start held for two cycles is never missed;
- that a reset in mid-run clears the result and leaves the unit ready for a fresh computation.

// File: rtl/gcd_sub_pkg.sv
package gcd_sub_pkg;

   typedef enum logic [3:0] {
      ST_IDLE    = 4'd0,
      ST_WAIT    = 4'd1,
      ST_WJOIN   = 4'd2,
      ST_LOAD_A  = 4'd3,
      ST_LOAD_B  = 4'd4,
      ST_TEST_NE = 4'd5,
      ST_TEST_LT = 4'd6,
      ST_UPD_B   = 4'd7,
      ST_UPD_A   = 4'd8,
      ST_IJOIN   = 4'd9,
      ST_OJOIN   = 4'd10,
      ST_OUTPUT  = 4'd11,
      ST_LOOP    = 4'd12
   } gcd_state_t;

   localparam int unsigned STATE_COUNT = 13;

   typedef struct packed {
      logic a_pick;
      logic b_pick;
      logic a_load;
      logic b_load;
      logic res_load;
   } gcd_ctl_t;

endpackage

// File: rtl/gcd_opreg.sv
module gcd_opreg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] ext_val,
   input  logic [WIDTH-1:0] sub_val,
   input  logic             pick,
   input  logic             load,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] mux_out;

   always_comb mux_out = pick ? sub_val : ext_val;

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= mux_out;
   end

   // R3: a load with select 0 captures the external operand
   p_ext_capture_r3: assert property (@(posedge clk) disable iff (rst)
      (load && !pick) |=> (q == $past(ext_val)));

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
   import gcd_sub_pkg::*;
#(
   parameter int unsigned WIDTH          = 8,
   parameter bit          LT_FROM_BORROW = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  gcd_ctl_t         ctl,
   output logic             ne_flag,
   output logic             lt_flag,
   output logic [WIDTH-1:0] result
);

   localparam int unsigned EXT_W = WIDTH + 1;

   logic [WIDTH-1:0] reg_a, reg_b;
   logic [WIDTH-1:0] a_minus_b, b_minus_a;

   always_comb begin
      a_minus_b = reg_a - reg_b;
      b_minus_a = reg_b - reg_a;
      ne_flag   = |(reg_a ^ reg_b);
   end

   generate
      if (LT_FROM_BORROW) begin : g_lt_borrow
         logic [EXT_W-1:0] wide_diff;
         always_comb begin
            wide_diff = {1'b0, reg_a} - {1'b0, reg_b};
            lt_flag   = wide_diff[EXT_W-1];
         end
      end else begin : g_lt_compare
         always_comb lt_flag = (reg_a < reg_b);
      end
   endgenerate

   gcd_opreg #(.WIDTH(WIDTH)) i_reg_a (
      .clk(clk), .rst(rst), .ext_val(opnd_a), .sub_val(a_minus_b),
      .pick(ctl.a_pick), .load(ctl.a_load), .q(reg_a));

   gcd_opreg #(.WIDTH(WIDTH)) i_reg_b (
      .clk(clk), .rst(rst), .ext_val(opnd_b), .sub_val(b_minus_a),
      .pick(ctl.b_pick), .load(ctl.b_load), .q(reg_b));

   always_ff @(posedge clk) begin
      if (rst)               result <= '0;
      else if (ctl.res_load) result <= reg_a;
   end

   // R4: B-update only when B is the larger, A-update only when A is not smaller
   p_no_wrap_b_r4: assert property (@(posedge clk) disable iff (rst)
      (ctl.b_load && ctl.b_pick) |-> (reg_b > reg_a));
   p_no_wrap_a_r4: assert property (@(posedge clk) disable iff (rst)
      (ctl.a_load && ctl.a_pick) |-> (reg_a > reg_b));
   // R6: result is loaded only from equal working values
   p_res_equal_r6: assert property (@(posedge clk) disable iff (rst)
      ctl.res_load |-> (reg_a == reg_b));
   // R7: result holds whenever it is not loaded
   p_res_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !ctl.res_load |=> $stable(result));

endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
   import gcd_sub_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     start,
   input  logic     ne_flag,
   input  logic     lt_flag,
   output gcd_ctl_t ctl
);

   gcd_state_t st, st_nx;

   always_ff @(posedge clk) begin
      if (rst) st <= ST_IDLE;
      else     st <= st_nx;
   end

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:    st_nx = ST_WAIT;
         ST_WAIT:    st_nx = start ? ST_LOAD_A : ST_WJOIN;
         ST_WJOIN:   st_nx = ST_WAIT;
         ST_LOAD_A:  st_nx = ST_LOAD_B;
         ST_LOAD_B:  st_nx = ST_TEST_NE;
         ST_TEST_NE: st_nx = ne_flag ? ST_TEST_LT : ST_OUTPUT;
         ST_TEST_LT: st_nx = lt_flag ? ST_UPD_B : ST_UPD_A;
         ST_UPD_B:   st_nx = ST_IJOIN;
         ST_UPD_A:   st_nx = ST_IJOIN;
         ST_IJOIN:   st_nx = ST_OJOIN;
         ST_OJOIN:   st_nx = ST_TEST_NE;
         ST_OUTPUT:  st_nx = ST_LOOP;
         ST_LOOP:    st_nx = ST_IDLE;
         default:    st_nx = ST_IDLE;
      endcase
   end

   always_comb begin
      ctl = '0;
      unique case (st)
         ST_LOAD_A: ctl.a_load = 1'b1;
         ST_LOAD_B: ctl.b_load = 1'b1;
         ST_UPD_B:  begin ctl.b_pick = 1'b1; ctl.b_load = 1'b1; end
         ST_UPD_A:  begin ctl.a_pick = 1'b1; ctl.a_load = 1'b1; end
         ST_OUTPUT: ctl.res_load = 1'b1;
         default:   ctl = '0;
      endcase
   end

   // R8: only the thirteen defined codes are ever held
   p_state_range_r8: assert property (@(posedge clk) disable iff (rst)
      (st <= ST_LOOP));
   // R2: a missing start sends wait to join, and join always returns to wait
   p_wait_join_r2: assert property (@(posedge clk) disable iff (rst)
      (st == ST_WAIT && !start) |=> (st == ST_WJOIN));
   p_join_back_r2: assert property (@(posedge clk) disable iff (rst)
      (st == ST_WJOIN) |=> (st == ST_WAIT));
   // R3: operand B is captured right after operand A
   p_load_order_r3: assert property (@(posedge clk) disable iff (rst)
      (st == ST_LOAD_A) |=> (st == ST_LOAD_B));
   // R5: every update returns through both joins to the inequality test
   p_join_path_r5: assert property (@(posedge clk) disable iff (rst)
      (st == ST_IJOIN) |=> (st == ST_OJOIN));
   p_join_ret_r5: assert property (@(posedge clk) disable iff (rst)
      (st == ST_OJOIN) |=> (st == ST_TEST_NE));
   // R6: equality at the test leads to the output state
   p_eq_out_r6: assert property (@(posedge clk) disable iff (rst)
      (st == ST_TEST_NE && !ne_flag) |=> (st == ST_OUTPUT));
   // R8: output is followed by loop-back and then idle
   p_loop_back_r8: assert property (@(posedge clk) disable iff (rst)
      (st == ST_OUTPUT) |=> (st == ST_LOOP));

endmodule

// File: rtl/gcd_sub_unit.sv
module gcd_sub_unit
   import gcd_sub_pkg::*;
#(
   parameter int unsigned WIDTH          = 8,
   parameter bit          LT_FROM_BORROW = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] gcd_out
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("gcd_sub_unit: WIDTH must be at least 2");
      end
   endgenerate

   gcd_ctl_t ctl;
   logic     ne_flag, lt_flag;

   gcd_ctrl i_ctrl (
      .clk(clk), .rst(rst), .start(start),
      .ne_flag(ne_flag), .lt_flag(lt_flag), .ctl(ctl));

   gcd_datapath #(.WIDTH(WIDTH), .LT_FROM_BORROW(LT_FROM_BORROW)) i_dp (
      .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .ctl(ctl), .ne_flag(ne_flag), .lt_flag(lt_flag), .result(gcd_out));

   // R1: result is zero right after a reset cycle
   p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (gcd_out == '0));

endmodule

// File: tb/test_gcd_sub_unit.sv
module test_gcd_sub_unit;

   localparam int unsigned W    = 8;
   localparam int unsigned WAIT = 6 * (1 << W) + 20;
   localparam int unsigned NVEC = 12;
   // each entry {a, b, expected gcd}
   localparam logic [3*W-1:0] VEC [NVEC] = '{
      {8'd12,  8'd18,  8'd6},
      {8'd42,  8'd8,   8'd2},
      {8'd17,  8'd17,  8'd17},
      {8'd1,   8'd200, 8'd1},
      {8'd255, 8'd1,   8'd1},
      {8'd100, 8'd75,  8'd25},
      {8'd7,   8'd13,  8'd1},
      {8'd144, 8'd96,  8'd48},
      {8'd1,   8'd1,   8'd1},
      {8'd255, 8'd255, 8'd255},
      {8'd128, 8'd64,  8'd64},
      {8'd81,  8'd27,  8'd27}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start = 1'b0;
   logic [W-1:0] opnd_a = '0, opnd_b = '0;
   logic [W-1:0] gcd_out;
   int           total = 0, bad = 0;
   int           cyc = 0;

   always #2 clk = ~clk;

   gcd_sub_unit #(.WIDTH(W)) i_gcd_sub_unit (
      .clk(clk), .rst(rst), .start(start),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .gcd_out(gcd_out));

   function automatic logic [W-1:0] ref_gcd(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] x = a, y = b, t;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      opnd_a = a;
      opnd_b = b;
      start  = 1'b1;
      cycles(2);
      start  = 1'b0;
   endtask

   task automatic run_pair(input string req, input logic [W-1:0] a,
                           input logic [W-1:0] b, input logic [W-1:0] exp);
      launch(a, b);
      cycles(WAIT);
      check(req, gcd_out, exp);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      cycles(3);
      // R1: reset state
      check("R1 reset", gcd_out, '0);
      rst = 1'b0;
      // R2: without start, operand changes do nothing
      for (int i = 0; i < 20; i++) begin
         opnd_a = W'(i * 7 + 3);
         opnd_b = W'(i * 5 + 1);
         cycles(3);
      end
      check("R2 no start", gcd_out, '0);

      // R3 R4 R5 R6 R9: table of vectors
      for (int i = 0; i < NVEC; i++)
         run_pair("R9 table", VEC[i][3*W-1:2*W], VEC[i][2*W-1:W], VEC[i][W-1:0]);

      // R9: pseudo-random nonzero pairs against a modulo-based reference
      for (int i = 0; i < 8; i++) begin
         logic [W-1:0] a, b;
         a = W'($urandom_range(255, 1));
         b = W'($urandom_range(255, 1));
         run_pair("R9 random", a, b, ref_gcd(a, b));
      end

      // R7: result holds the previous value during a long computation
      run_pair("R7 setup", 8'd30, 8'd45, 8'd15);
      launch(8'd255, 8'd2);
      cycles(40);
      check("R7 hold mid-run", gcd_out, 8'd15);
      cycles(WAIT);
      check("R7 final", gcd_out, 8'd1);

      // R8: unit returns to wait and accepts the next start promptly
      launch(8'd6, 8'd6);
      cycles(12);
      check("R8 quick restart", gcd_out, 8'd6);

      // R10: reset mid-run clears result, then a fresh run succeeds
      launch(8'd255, 8'd1);
      cycles(100);
      rst = 1'b1;
      cycles(2);
      rst = 1'b0;
      check("R1 R10 mid-run reset", gcd_out, '0);
      cycles(WAIT);
      check("R10 abandoned stays clear", gcd_out, '0);
      run_pair("R10 after reset", 8'd12, 8'd18, 8'd6);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule